// File: doc/BRIEF.md
# Instruction FIFO with Latched Buffer Enable

This block sits between a parallel host port and a slower back-end that consumes write instructions one at a time. In buffered mode it queues up to 128 instruction words, so the host can issue writes back to back at full bus speed and leave while the back-end drains the queue. A write that arrives while the queue is full is dropped with no error response.

Buffering is chosen by an enable strap and a parallel-mode select. Both are sampled only on the first clock edge after reset and on every clear cycle, and the sampled value holds until the next such event. Buffered mode is used only when the enable was high and the parallel interface was selected. In every other case the block passes each write straight through to the consumer, and the host must hold off while the busy output is high. A clear or a reset empties the queue and returns both pointers to zero.

Top module: `instr_fifo`

## Requirements
- R1: After reset, with `wr_valid_i` low, `empty_o` is 1, `full_o` is 0 and `rd_valid_o` is 0.
- R2: In buffered mode, words leave in the order they were accepted, and all 24 bits come out unchanged, including reserved bits [23:21]. The word layout is channel [20:16], register select [15:14] and data [13:0].
- R3: In buffered mode the queue holds 128 words. `full_o` rises on the cycle after the 128th accepted write that had no pop with it, and `full_o` and `empty_o` are never high together.
- R4: A write while `full_o` is high and no pop happens is discarded. The queue keeps its first 128 words, and the discarded word never appears on the output.
- R5: A write and a pop in the same cycle while full are both accepted. `full_o` stays high, and the new word goes to the tail.
- R6: In buffered mode `rd_valid_o` equals the inverse of `empty_o`. One word is removed on each clock edge where `rd_valid_o` and `rd_ready_i` are both high.
- R7: `fifo_en_i` and `par_mode_i` are sampled only on the first edge after reset and on an edge where `clear_i` is high. A later change has no effect until the next clear.
- R8: In pass-through mode (latched enable low or parallel mode not selected), `rd_valid_o` follows `wr_valid_i` and `rd_data_o` follows `wr_data_i` in the same cycle. `busy_o` equals the inverse of `rd_ready_i`, and `empty_o` stays 1.
- R9: A cycle with `clear_i` high empties the queue and resets both pointers. A write in that cycle is dropped, and the next accepted word becomes the head.
- R10: In buffered mode `busy_o` is 0, even when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Synchronous flush; also re-samples the mode straps |
| fifo_en_i | input | 1 | Buffer enable strap, active high |
| par_mode_i | input | 1 | High when the parallel host interface is selected |
| wr_valid_i | input | 1 | Host write strobe |
| wr_data_i | input | 24 | Host instruction word |
| busy_o | output | 1 | Host must hold off (pass-through mode only) |
| full_o | output | 1 | Queue holds 128 words |
| empty_o | output | 1 | Queue holds no words |
| rd_valid_o | output | 1 | Instruction available to the consumer |
| rd_data_o | output | 24 | Instruction word to the consumer |
| rd_ready_i | input | 1 | Consumer accepts the presented word |

## Verification
The bench fills the queue to exactly 128 words and keeps writing. A design that wraps its write pointer would overwrite the head and return a late word first during the drain. It issues a write and a pop together while the queue is full, which catches a design that refuses the push on full without looking at the pop; that design would lose the tail word. It changes the straps between clears and checks that the mode holds, which exposes a design that follows the enable live and starts storing words or passing them through at the wrong time. It also writes during a clear, which a design that did not give the flush priority would leave as a stale head entry.

// File: rtl/instr_fifo_pkg.sv
package instr_fifo_pkg;
  localparam int unsigned INSTR_W = 24;

  typedef struct packed {
    logic [2:0]  rsvd;
    logic [4:0]  chan;
    logic [1:0]  sel;
    logic [13:0] data;
  } instr_t;
endpackage

// File: rtl/instr_fifo_mode_latch.sv
module instr_fifo_mode_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  input  logic par_i,
  output logic buf_mode_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b1;
      buf_mode_o <= 1'b0;
    end else begin
      pend_q <= 1'b0;
      if (pend_q || clear_i) buf_mode_o <= en_i & par_i;
    end
  end
endmodule

// File: rtl/instr_fifo_store.sv
module instr_fifo_store #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW:0]      wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q[AW-1:0]] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_ptr_q[AW-1:0]];
  assign empty_o = (wr_ptr_q == rd_ptr_q);
  assign full_o  = (wr_ptr_q[AW] != rd_ptr_q[AW]) &&
                   (wr_ptr_q[AW-1:0] == rd_ptr_q[AW-1:0]);
endmodule

// File: rtl/instr_fifo.sv
module instr_fifo
  import instr_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               fifo_en_i,
  input  logic               par_mode_i,
  input  logic               wr_valid_i,
  input  logic [INSTR_W-1:0] wr_data_i,
  output logic               busy_o,
  output logic               full_o,
  output logic               empty_o,
  output logic               rd_valid_o,
  output logic [INSTR_W-1:0] rd_data_o,
  input  logic               rd_ready_i
);
  logic               buf_mode;
  logic               q_full, q_empty, push, pop;
  logic [INSTR_W-1:0] q_rdata;

  instr_fifo_mode_latch i_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .en_i      (fifo_en_i),
    .par_i     (par_mode_i),
    .buf_mode_o(buf_mode)
  );

  // pop frees a slot in the same cycle, so a full queue still takes a push
  assign pop  = buf_mode & ~clear_i & rd_ready_i & ~q_empty;
  assign push = buf_mode & ~clear_i & wr_valid_i & (~q_full | pop);

  instr_fifo_store #(.DEPTH(DEPTH), .WIDTH(INSTR_W)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(clear_i),
    .push_i (push),
    .pop_i  (pop),
    .wdata_i(wr_data_i),
    .rdata_o(q_rdata),
    .full_o (q_full),
    .empty_o(q_empty)
  );

  always_comb begin
    if (buf_mode) begin
      rd_valid_o = ~q_empty & ~clear_i;
      rd_data_o  = q_rdata;
      busy_o     = 1'b0;
    end else begin
      rd_valid_o = wr_valid_i & ~clear_i;
      rd_data_o  = wr_data_i;
      busy_o     = ~rd_ready_i;
    end
  end

  assign full_o  = q_full;
  assign empty_o = q_empty;
endmodule

// File: rtl/instr_fifo_chk.sv
module instr_fifo_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clear_i,
  input logic wr_valid_i,
  input logic rd_ready_i,
  input logic busy_o,
  input logic full_o,
  input logic empty_o,
  input logic rd_valid_o,
  input logic buf_mode
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 1'b1;
  end

  assert_full_empty_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_valid_i && !rd_ready_i && !clear_i) |=> full_o);

  assert_full_pushpop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_valid_i && rd_ready_i && !clear_i) |=> full_o);

  assert_valid_tracks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_mode && !clear_i) |-> (rd_valid_o == !empty_o));

  assert_mode_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2 && !$past(clear_i)) |-> $stable(buf_mode));

  assert_bypass_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_mode |-> (empty_o && !full_o));

  assert_clear_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> empty_o);

  assert_no_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_mode |-> !busy_o);
endmodule

bind instr_fifo instr_fifo_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clear_i   (clear_i),
  .wr_valid_i(wr_valid_i),
  .rd_ready_i(rd_ready_i),
  .busy_o    (busy_o),
  .full_o    (full_o),
  .empty_o   (empty_o),
  .rd_valid_o(rd_valid_o),
  .buf_mode  (buf_mode)
);

// File: tb/test_instr_fifo.sv
module test_instr_fifo;
  import instr_fifo_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic clk_i = 1'b0, rst_ni = 1'b0, clear_i = 1'b0;
  logic fifo_en_i = 1'b0, par_mode_i = 1'b0, wr_valid_i = 1'b0, rd_ready_i = 1'b0;
  logic [INSTR_W-1:0] wr_data_i = '0;
  logic busy_o, full_o, empty_o, rd_valid_o;
  logic [INSTR_W-1:0] rd_data_o;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  instr_fifo #(.DEPTH(DEPTH)) i_instr_fifo (.*);

  function automatic logic [INSTR_W-1:0] word(int i);
    instr_t w;
    w.rsvd = 3'(i + 5);
    w.chan = 5'(i);
    w.sel  = 2'(i >> 2);
    w.data = 14'(i * 97 + 1234);
    return w;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset(logic en, logic par);
    wr_valid_i = 0; rd_ready_i = 0; clear_i = 0;
    fifo_en_i = en; par_mode_i = par;
    rst_ni = 0;
    tick(); tick();
    rst_ni = 1;
    #1;
    chk(empty_o === 1'b1, "R1 empty", 32'(empty_o), 1);
    chk(full_o === 1'b0, "R1 full", 32'(full_o), 0);
    chk(rd_valid_o === 1'b0, "R1 valid", 32'(rd_valid_o), 0);
    tick();
  endtask

  task automatic push(logic [INSTR_W-1:0] d);
    wr_valid_i = 1; wr_data_i = d;
    tick();
    wr_valid_i = 0;
  endtask

  task automatic t_order();
    do_reset(1, 1);
    for (int i = 0; i < 5; i++) push(word(i));
    for (int i = 0; i < 5; i++) begin
      #1;
      chk(rd_valid_o === 1'b1, "R6 valid", 32'(rd_valid_o), 1);
      chk(rd_data_o === word(i), "R2 order", 32'(rd_data_o), 32'(word(i)));
      rd_ready_i = 1;
      tick();
      rd_ready_i = 0;
    end
    chk(empty_o === 1'b1 && rd_valid_o === 1'b0, "R6 drained", 32'(empty_o), 1);
  endtask

  task automatic t_fill_drop();
    do_reset(1, 1);
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) chk(full_o === 1'b0, "R3 not full early", 32'(full_o), 0);
      push(word(i));
    end
    chk(full_o === 1'b1, "R3 full", 32'(full_o), 1);
    chk(busy_o === 1'b0, "R10 busy", 32'(busy_o), 0);
    for (int k = 0; k < 3; k++) push(word(500 + k));
    chk(full_o === 1'b1, "R4 still full", 32'(full_o), 1);
    wr_valid_i = 1; wr_data_i = word(900); rd_ready_i = 1;
    #1;
    chk(rd_data_o === word(0), "R4 head kept", 32'(rd_data_o), 32'(word(0)));
    tick();
    wr_valid_i = 0;
    chk(full_o === 1'b1, "R5 full after push+pop", 32'(full_o), 1);
    for (int i = 1; i < DEPTH; i++) begin
      chk(rd_data_o === word(i), "R4 drain", 32'(rd_data_o), 32'(word(i)));
      tick();
    end
    chk(rd_data_o === word(900), "R5 tail", 32'(rd_data_o), 32'(word(900)));
    tick();
    rd_ready_i = 0;
    chk(empty_o === 1'b1, "R6 empty after drain", 32'(empty_o), 1);
  endtask

  task automatic t_latch();
    do_reset(1, 1);
    fifo_en_i = 0;
    tick();
    push(word(1));
    chk(empty_o === 1'b0 && rd_data_o === word(1), "R7 still buffered",
        32'(rd_data_o), 32'(word(1)));
    clear_i = 1; tick(); clear_i = 0;
    chk(empty_o === 1'b1, "R9 clear empties", 32'(empty_o), 1);
    wr_valid_i = 1; wr_data_i = word(2); rd_ready_i = 0;
    #1;
    chk(rd_valid_o === 1'b1 && rd_data_o === word(2), "R8 pass data",
        32'(rd_data_o), 32'(word(2)));
    chk(busy_o === 1'b1, "R8 busy", 32'(busy_o), 1);
    rd_ready_i = 1;
    #1;
    chk(busy_o === 1'b0, "R8 not busy", 32'(busy_o), 0);
    rd_ready_i = 0;
    fifo_en_i = 1;
    tick(); tick();
    wr_valid_i = 0;
    #1;
    chk(empty_o === 1'b1 && rd_valid_o === 1'b0, "R7 still bypass",
        32'(rd_valid_o), 0);
  endtask

  task automatic t_serial();
    do_reset(1, 0);
    wr_valid_i = 1; wr_data_i = word(3); rd_ready_i = 0;
    tick();
    chk(rd_valid_o === 1'b1 && rd_data_o === word(3), "R8 serial pass",
        32'(rd_data_o), 32'(word(3)));
    chk(empty_o === 1'b1, "R8 nothing stored", 32'(empty_o), 1);
    wr_valid_i = 0;
    #1;
    chk(rd_valid_o === 1'b0, "R8 valid follows", 32'(rd_valid_o), 0);
  endtask

  task automatic t_clear();
    do_reset(1, 1);
    for (int i = 0; i < 3; i++) push(word(40 + i));
    clear_i = 1; wr_valid_i = 1; wr_data_i = word(7);
    tick();
    clear_i = 0; wr_valid_i = 0;
    chk(empty_o === 1'b1 && rd_valid_o === 1'b0, "R9 flushed", 32'(empty_o), 1);
    push(word(8));
    chk(rd_data_o === word(8), "R9 new head", 32'(rd_data_o), 32'(word(8)));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_order();
    t_fill_drop();
    t_latch();
    t_serial();
    t_clear();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule